// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Front End

This block is a synthesizable cycle model of a pipelined synchronous SRAM whose ports move two data words for each address. It runs on one clock. Each clock period holds two beat slots. The early slot stands for the rising edge of the main clock, and the late slot stands for the rising edge of its complement. Write data enters through one input bus per slot. Read data leaves through one output bus per slot, and each output bus has its own valid flag.

A command (read or write select plus address) is taken only in every second cycle, so one burst begins every two cycles. A one-bit burst counter chooses which word of the addressed pair moves first. A build parameter selects between two variants. In one, the counter always starts at zero. In the other, it loads the address LSB and wraps inside the pair. A per-command mode input selects the read return timing: a 1.5-cycle latency that stands for a running delay-locked loop, or a 1.0-cycle latency.

Top module: `ddr2b_sram`

## Requirements
- R1: The first cycle after reset ends is a command slot. After that, command slots fall on every second cycle (cycle 0, 2, 4, ... counted from reset release). The select, address and mode inputs in the cycles between slots have no effect on memory or outputs.
- R2: For an accepted write, the word on `wr_dk` in the next cycle is stored at the first burst address, and the word on `wr_dkb` in that cycle is stored at the second burst address.
- R3: With `SEED_LSB` = 1, the first burst address is `addr` and the second is `addr` with bit 0 inverted. The upper bits never change, so address 63 is followed by 62.
- R4: With `SEED_LSB` = 0, the first burst address is `addr` with bit 0 forced to 0 and the second has bit 0 forced to 1, whatever `addr[0]` is.
- R5: If `rd_n` and `wr_n` are both low in a command slot, a read is carried out and the write is dropped. Its data beats leave memory unchanged.
- R6: A read accepted in cycle t with `lat_mode` = 1 returns its first word on `rd_qkb` (`rd_vkb` high) in cycle t+1, and its second word on `rd_qk` (`rd_vk` high) in cycle t+2.
- R7: A read accepted in cycle t with `lat_mode` = 0 returns its first word on `rd_qk` and its second word on `rd_qkb` in cycle t+1, with both valids high.
- R8: During reset and in every slot that carries no read beat, the slot's valid is low and its data bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; each period holds an early and a late beat slot |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Active-low read select, taken in command slots |
| wr_n | input | 1 | Active-low write select, taken in command slots |
| addr | input | ADDR_W | Word address of the burst |
| lat_mode | input | 1 | 1: 1.5-cycle read latency, 0: 1.0-cycle read latency |
| wr_dk | input | DATA_W | Write word for the early slot of the cycle after a write command |
| wr_dkb | input | DATA_W | Write word for the late slot of the cycle after a write command |
| rd_qk | output | DATA_W | Read word in the early slot |
| rd_vk | output | 1 | Early-slot read word valid |
| rd_qkb | output | DATA_W | Read word in the late slot |
| rd_vkb | output | 1 | Late-slot read word valid |

## Verification
A slot counter that has slipped out of phase shows up at the ports within two cycles. Commands are then taken on odd cycles, so read beats land one cycle from where the scoreboard expects them, and writes store the wrong beat data. A burst counter that starts at the wrong value swaps the two words of every read of an odd address. A counter that carries into the upper bits corrupts the neighbouring pair, which the next read of that pair exposes. A stale return stage shows up on the first read as a missing second beat, or as valid and data in a slot that should be empty.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // starting value of the one-bit burst counter
    function automatic logic burst_start(input bit seed_en, input logic lsb);
        return seed_en ? lsb : 1'b0;
    endfunction

    // beat slot phase toggles every cycle; 0 marks a command slot
    function automatic logic next_phase(input logic cur);
        return ~cur;
    endfunction

endpackage

// File: rtl/ddr2b_cmd.sv
module ddr2b_cmd
    import ddr2b_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter bit SEED_LSB = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lat_mode,
    output logic              op_slot,
    output logic              go_rd,
    output logic              go_wr,
    output logic              go_late,
    output logic [ADDR_W-1:0] a_first,
    output logic [ADDR_W-1:0] a_second
);
    logic phase;
    logic start;
    op_e  op;

    always_ff @(posedge clk) begin
        if (rst) phase <= 1'b0;
        else     phase <= next_phase(phase);
    end

    assign op_slot = !rst && !phase;

    always_comb begin
        op = OP_IDLE;
        if (op_slot) begin
            if (!rd_n)      op = OP_READ;   // read outranks write
            else if (!wr_n) op = OP_WRITE;
        end
    end

    assign go_rd   = (op == OP_READ);
    assign go_wr   = (op == OP_WRITE);
    assign go_late = go_rd && lat_mode;

    generate
        if (SEED_LSB) begin : g_seeded
            assign start = burst_start(1'b1, addr[0]);
        end else begin : g_zero
            assign start = burst_start(1'b0, 1'b0);
        end
    endgenerate

    // wrap inside the pair: upper bits pass through untouched
    assign a_first  = {addr[ADDR_W-1:1], start};
    assign a_second = {addr[ADDR_W-1:1], ~start};

    a_r1_spacing: assert property (@(posedge clk) disable iff (rst)
        (go_rd || go_wr) |=> !(go_rd || go_wr))
        else $error("a_r1_spacing");

endmodule

// File: rtl/ddr2b_wcap.sv
module ddr2b_wcap #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_wr,
    input  logic [ADDR_W-1:0] a_first,
    input  logic [ADDR_W-1:0] a_second,
    input  logic [DATA_W-1:0] wr_dk,
    input  logic [DATA_W-1:0] wr_dkb,
    output logic              we,
    output logic [ADDR_W-1:0] wa0,
    output logic [ADDR_W-1:0] wa1,
    output logic [DATA_W-1:0] wd0,
    output logic [DATA_W-1:0] wd1
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] a0;
        logic [ADDR_W-1:0] a1;
    } pend_t;

    pend_t pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend.vld <= go_wr;
            if (go_wr) begin
                pend.a0 <= a_first;
                pend.a1 <= a_second;
            end
        end
    end

    // both beats of the data cycle commit at its closing edge
    assign we  = pend.vld;
    assign wa0 = pend.a0;
    assign wa1 = pend.a1;
    assign wd0 = wr_dk;
    assign wd1 = wr_dkb;

    a_r2_commit_follows_cmd: assert property (@(posedge clk) disable iff (rst)
        we |-> $past(go_wr))
        else $error("a_r2_commit_follows_cmd");

endmodule

// File: rtl/ddr2b_array.sv
module ddr2b_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa0,
    input  logic [ADDR_W-1:0] wa1,
    input  logic [DATA_W-1:0] wd0,
    input  logic [DATA_W-1:0] wd1,
    input  logic [ADDR_W-1:0] ra0,
    input  logic [ADDR_W-1:0] ra1,
    output logic [DATA_W-1:0] rd0,
    output logic [DATA_W-1:0] rd1
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa0] <= wd0;
            mem[wa1] <= wd1;
        end
    end

    assign rd0 = mem[ra0];
    assign rd1 = mem[ra1];

endmodule

// File: rtl/ddr2b_rret.sv
module ddr2b_rret #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_rd,
    input  logic              go_late,
    input  logic [DATA_W-1:0] rd0,
    input  logic [DATA_W-1:0] rd1,
    output logic [DATA_W-1:0] rd_qk,
    output logic              rd_vk,
    output logic [DATA_W-1:0] rd_qkb,
    output logic              rd_vkb
);
    typedef struct packed {
        logic              vld;
        logic              late;
        logic [DATA_W-1:0] w0;
        logic [DATA_W-1:0] w1;
    } stg1_t;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] w;
    } stg2_t;

    stg1_t s1;
    stg2_t s2;
    logic  early_pair;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1.vld <= go_rd;
            if (go_rd) begin
                s1.late <= go_late;
                s1.w0   <= rd0;
                s1.w1   <= rd1;
            end
            s2.vld <= s1.vld && s1.late;
            if (s1.vld && s1.late) s2.w <= s1.w1;
        end
    end

    assign early_pair = s1.vld && !s1.late;

    always_comb begin
        rd_vk  = early_pair || s2.vld;
        rd_qk  = '0;
        if (s2.vld)          rd_qk = s2.w;
        else if (early_pair) rd_qk = s1.w0;
        rd_vkb = s1.vld;
        rd_qkb = '0;
        if (s1.vld) rd_qkb = s1.late ? s1.w0 : s1.w1;
    end

    a_r6_second_beat: assert property (@(posedge clk) disable iff (rst)
        (rd_vkb && !rd_vk) |=> (rd_vk && !rd_vkb))
        else $error("a_r6_second_beat");

    a_r7_same_cycle: assert property (@(posedge clk) disable iff (rst)
        (rd_vk && rd_vkb) |-> $past(go_rd && !go_late))
        else $error("a_r7_same_cycle");

    a_r8_kb_needs_read: assert property (@(posedge clk) disable iff (rst)
        rd_vkb |-> $past(go_rd))
        else $error("a_r8_kb_needs_read");

endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
    import ddr2b_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 18,
    parameter bit SEED_LSB = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lat_mode,
    input  logic [DATA_W-1:0] wr_dk,
    input  logic [DATA_W-1:0] wr_dkb,
    output logic [DATA_W-1:0] rd_qk,
    output logic              rd_vk,
    output logic [DATA_W-1:0] rd_qkb,
    output logic              rd_vkb
);
    logic              op_slot, go_rd, go_wr, go_late;
    logic [ADDR_W-1:0] a_first, a_second;
    logic              we;
    logic [ADDR_W-1:0] wa0, wa1;
    logic [DATA_W-1:0] wd0, wd1, rd0, rd1;

    ddr2b_cmd #(.ADDR_W(ADDR_W), .SEED_LSB(SEED_LSB)) u_cmd (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .lat_mode(lat_mode), .op_slot(op_slot), .go_rd(go_rd), .go_wr(go_wr),
        .go_late(go_late), .a_first(a_first), .a_second(a_second)
    );

    ddr2b_wcap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wcap (
        .clk(clk), .rst(rst), .go_wr(go_wr), .a_first(a_first),
        .a_second(a_second), .wr_dk(wr_dk), .wr_dkb(wr_dkb),
        .we(we), .wa0(wa0), .wa1(wa1), .wd0(wd0), .wd1(wd1)
    );

    ddr2b_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .we(we), .wa0(wa0), .wa1(wa1), .wd0(wd0), .wd1(wd1),
        .ra0(a_first), .ra1(a_second), .rd0(rd0), .rd1(rd1)
    );

    ddr2b_rret #(.DATA_W(DATA_W)) u_rret (
        .clk(clk), .rst(rst), .go_rd(go_rd), .go_late(go_late),
        .rd0(rd0), .rd1(rd1), .rd_qk(rd_qk), .rd_vk(rd_vk),
        .rd_qkb(rd_qkb), .rd_vkb(rd_vkb)
    );

    a_r3_pair_wrap: assert property (@(posedge clk) disable iff (rst)
        we |-> (wa0[ADDR_W-1:1] == wa1[ADDR_W-1:1]) && (wa0[0] != wa1[0]))
        else $error("a_r3_pair_wrap");

    a_r5_read_wins: assert property (@(posedge clk) disable iff (rst)
        (op_slot && !rd_n && !wr_n) |=> !we)
        else $error("a_r5_read_wins");

    generate
        if (!SEED_LSB) begin : g_zero_chk
            a_r4_zero_start: assert property (@(posedge clk) disable iff (rst)
                we |-> !wa0[0])
                else $error("a_r4_zero_start");
        end
    endgenerate

endmodule

// File: tb/ddr2b_sram_bench.sv
module ddr2b_sram_bench;
    localparam int AW = 6;
    localparam int DW = 18;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        int          cyc;
        bit          slot;   // 0: early, 1: late
        logic [DW-1:0] dw;
        logic [DW-1:0] dn;
        string       req;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_n = 1'b1, wr_n = 1'b1, lat_mode = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_dk = '0, wr_dkb = '0;
    logic [DW-1:0] qk, qkb, nqk, nqkb;
    logic vk, vkb, nvk, nvkb;

    int total = 0, bad = 0, cyc = 0;
    bit run = 1'b0, done = 1'b0;
    item_t sb[$];
    logic [DW-1:0] refw [DEPTH];
    logic [DW-1:0] refn [DEPTH];

    always #5 clk = ~clk;

    ddr2b_sram #(.ADDR_W(AW), .DATA_W(DW), .SEED_LSB(1'b1)) u_ddr2b_sram (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .lat_mode(lat_mode), .wr_dk(wr_dk), .wr_dkb(wr_dkb),
        .rd_qk(qk), .rd_vk(vk), .rd_qkb(qkb), .rd_vkb(vkb)
    );

    ddr2b_sram #(.ADDR_W(AW), .DATA_W(DW), .SEED_LSB(1'b0)) u_ddr2b_sram_narrow (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .lat_mode(lat_mode), .wr_dk(wr_dk), .wr_dkb(wr_dkb),
        .rd_qk(nqk), .rd_vk(nvk), .rd_qkb(nqkb), .rd_vkb(nvkb)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s cycle=%0d got=%0h exp=%0h", req, what, cyc, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        cyc++;
    endtask

    // monitor: pops expected beats and compares both variants
    task automatic mon_slot(input bit s, input logic v, input logic [DW-1:0] d,
                            input logic nv, input logic [DW-1:0] nd);
        item_t it;
        if (sb.size() > 0 && sb[0].cyc == cyc && sb[0].slot == s) begin
            it = sb.pop_front();
            chk(v == 1'b1, it.req, "wide valid", longint'(v), 1);
            chk(d == it.dw, it.req, "wide data", longint'(d), longint'(it.dw));
            chk(nv == 1'b1, it.req, "narrow valid", longint'(nv), 1);
            chk(nd == it.dn, it.req, "narrow data", longint'(nd), longint'(it.dn));
        end else begin
            chk(!v && d == '0, "R8", "idle slot wide", longint'({v, d}), 0);
            chk(!nv && nd == '0, "R8", "idle slot narrow", longint'({nv, nd}), 0);
        end
    endtask

    always @(negedge clk) begin
        if (run) begin
            mon_slot(1'b0, vk, qk, nvk, nqk);
            mon_slot(1'b1, vkb, qkb, nvkb, nqkb);
        end
    end

    // driver: one burst operation over a command cycle and a data cycle
    task automatic op(input bit rd, input bit wr, input logic [AW-1:0] a,
                      input bit late, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input bit junk, input string tag);
        logic [AW-1:0] wf, ws, nf, ns;
        item_t it;
        wf = a;
        ws = {a[AW-1:1], ~a[0]};
        nf = {a[AW-1:1], 1'b0};
        ns = {a[AW-1:1], 1'b1};
        rd_n = !rd; wr_n = !wr; addr = a; lat_mode = late;
        if (rd) begin
            it.req = tag;
            if (late) begin
                it.cyc = cyc + 1; it.slot = 1'b1; it.dw = refw[wf]; it.dn = refn[nf]; sb.push_back(it);
                it.cyc = cyc + 2; it.slot = 1'b0; it.dw = refw[ws]; it.dn = refn[ns]; sb.push_back(it);
            end else begin
                it.cyc = cyc + 1; it.slot = 1'b0; it.dw = refw[wf]; it.dn = refn[nf]; sb.push_back(it);
                it.cyc = cyc + 1; it.slot = 1'b1; it.dw = refw[ws]; it.dn = refn[ns]; sb.push_back(it);
            end
        end
        step();
        // data cycle: optional junk selects that must be ignored
        rd_n = !junk; wr_n = !junk; addr = ~a; lat_mode = ~late;
        wr_dk = d0; wr_dkb = d1;
        if (wr && !rd) begin
            refw[wf] = d0; refw[ws] = d1;
            refn[nf] = d0; refn[ns] = d1;
        end
        step();
        rd_n = 1'b1; wr_n = 1'b1; wr_dk = '0; wr_dkb = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R1", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin refw[i] = '0; refn[i] = '0; end
        repeat (3) @(posedge clk);
        #4;
        chk(!vk && !vkb && qk == '0 && qkb == '0, "R8", "reset outputs",
            longint'({vk, vkb, qk, qkb}), 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        cyc = 0;
        run = 1'b1;

        // R2: fill every pair, even address, first beat to the even word
        for (int p = 0; p < DEPTH / 2; p++)
            op(1'b0, 1'b1, AW'(2 * p), 1'b0, DW'(18'h1000 + p), DW'(18'h2000 + p), 1'b0, "R2");

        op(1'b1, 1'b0, 6'd4, 1'b1, '0, '0, 1'b0, "R6");
        op(1'b1, 1'b0, 6'd4, 1'b0, '0, '0, 1'b0, "R7");
        // R3/R4: odd address reads start mid-pair on wide, at 0 on narrow
        op(1'b1, 1'b0, 6'd7, 1'b1, '0, '0, 1'b0, "R3");
        op(1'b1, 1'b0, 6'd7, 1'b0, '0, '0, 1'b0, "R4");
        // odd address write then read both ways
        op(1'b0, 1'b1, 6'd9, 1'b0, 18'h0AAAA, 18'h15555, 1'b0, "R2");
        op(1'b1, 1'b0, 6'd9, 1'b0, '0, '0, 1'b0, "R3");
        op(1'b1, 1'b0, 6'd8, 1'b1, '0, '0, 1'b0, "R4");
        // R5: both selects, read wins, write data dropped
        op(1'b1, 1'b1, 6'd10, 1'b0, 18'h3FFFF, 18'h3F0F0, 1'b0, "R5");
        op(1'b1, 1'b0, 6'd10, 1'b1, '0, '0, 1'b0, "R5");
        // R1: selects in the data cycle are ignored
        op(1'b0, 1'b0, 6'd20, 1'b0, 18'h01234, 18'h04321, 1'b1, "R1");
        op(1'b1, 1'b0, 6'd43, 1'b0, '0, '0, 1'b1, "R1");
        op(1'b1, 1'b0, 6'd42, 1'b1, '0, '0, 1'b0, "R1");
        // R3: top-of-array wrap without carry, back-to-back mode switches
        op(1'b0, 1'b1, 6'd63, 1'b1, 18'h0BEEF, 18'h0CAFE, 1'b0, "R3");
        op(1'b1, 1'b0, 6'd63, 1'b1, '0, '0, 1'b0, "R3");
        op(1'b1, 1'b0, 6'd62, 1'b0, '0, '0, 1'b0, "R3");
        op(1'b1, 1'b0, 6'd63, 1'b0, '0, '0, 1'b0, "R7");
        op(1'b1, 1'b0, 6'd0, 1'b1, '0, '0, 1'b0, "R6");
        op(1'b1, 1'b0, 6'd1, 1'b1, '0, '0, 1'b0, "R6");

        repeat (6) step();
        chk(sb.size() == 0, "R6", "unreturned beats", longint'(sb.size()), 0);
        done = 1'b1;
        run = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule